// File: doc/BRIEF.md
# Serial Time/Date Sentence Decoder with Seven-Segment Output

This block sits behind a UART byte receiver and watches the stream of NMEA-0183 text sentences arriving from a satellite timing receiver. It follows each sentence from its `$` start character to its two-character checksum. It keeps a running XOR of the sentence body, counts comma-separated fields and stages the six time digits and the six date digits of the recommended-minimum sentence. It copies them to its display registers only when the whole sentence has been checked.

A single select input chooses whether the six displayed digits carry the time of day (hours, minutes, seconds) or the date (day, month, two-digit year). Each digit is driven as an active-low seven-segment pattern. Until the first good sentence has been accepted, every digit is blank and the valid flag is low. Sentences that are corrupted, too long, of another type or malformed leave the last good reading on the display.

Top module: `nmea_clock_display`

## Requirements
- R1: While reset is held and afterwards until the first accepted sentence, `disp_valid` is 0 and every bit of `seg_n` is 1 (all segments dark).
- R2: A sentence whose identifier ends in `RMC`, with well-formed time and date fields and a correct checksum, is accepted on the clock edge that samples its second checksum character. From the next cycle `disp_valid` is 1 and stays 1, and with `show_date`=0 the digits show the first six characters of field 1 (hhmmss).
- R3: With `show_date`=1 the digits show field 9 (ddmmyy). The select acts combinationally on the held values, with no new sentence needed.
- R4: Digit i of the six (i=0 is the first character received in the field) drives `seg_n[(5-i)*7 +: 7]` with bit order {g,f,e,d,c,b,a} and 0 meaning lit. The lit segments are: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg.
- R5: The checksum is the XOR of all characters strictly between `$` and `*`. It is given after `*` as two hex characters, most significant first, in upper or lower case. On a mismatch the displayed values are kept.
- R6: A sentence whose identifier (field 0) does not end in `RMC` changes nothing, even with a correct checksum.
- R7: The sentence is rejected if any of the first six characters of the time field or of the date field is not a decimal digit, or if the time field has fewer than six characters. It is also rejected if the date field is not exactly six characters long.
- R8: A `$` received at any point inside a sentence discards the partial sentence and starts a new one.
- R9: A sentence of at most 82 characters, counted from `$` to the last checksum character, can be accepted. When an 83rd character arrives, the sentence is dropped and the parser waits for `$`.
- R10: Characters beyond the sixth in the time field (such as a fractional-second suffix) are ignored.
- R11: A byte presented while `rx_valid` is 0 has no effect, even if it is `$`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe from the UART receiver |
| rx_byte | input | 8 | Received ASCII character |
| show_date | input | 1 | 0 selects time of day, 1 selects date |
| seg_n | output | 42 | Six active-low seven-segment patterns, first digit in the top bits |
| disp_valid | output | 1 | High once a sentence has been accepted |

## Verification
A wrong parser state or checksum accumulator appears at the ports in the cycle after the second checksum character. At that point a sentence the bench expects to be accepted leaves the display unchanged, or a sentence it expects to be rejected replaces the digits. Either shows up in the comparison that follows. A wrong field or digit position shows as a misplaced or stale digit on the next display comparison, and a wrong segment table shows at once for the digit value concerned. Every digit value is driven at every position under both selects, and each checksum bit is corrupted in turn, so a fault cannot stay hidden behind a single pattern.

// File: rtl/nmea_pkg.sv
package nmea_pkg;

  localparam int NDIG  = 6;
  localparam int SEG_W = 7;

  typedef logic [3:0] bcd_t;
  typedef logic [NDIG-1:0][3:0] digits_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BODY  = 2'd1,
    PH_CK_HI = 2'd2,
    PH_CK_LO = 2'd3
  } phase_t;

  localparam logic [7:0] CH_DOLLAR = 8'h24;
  localparam logic [7:0] CH_STAR   = 8'h2A;
  localparam logic [7:0] CH_COMMA  = 8'h2C;
  localparam logic [SEG_W-1:0] SEG_BLANK = 7'h7F;

  function automatic logic is_dec(input logic [7:0] c);
    return (c >= 8'h30) && (c <= 8'h39);
  endfunction

  function automatic logic is_hex(input logic [7:0] c);
    return is_dec(c) || ((c >= 8'h41) && (c <= 8'h46)) || ((c >= 8'h61) && (c <= 8'h66));
  endfunction

  function automatic logic [3:0] hex_val(input logic [7:0] c);
    logic [7:0] v;
    if (is_dec(c))        v = c - 8'h30;
    else if (c >= 8'h61)  v = c - 8'h57;
    else                  v = c - 8'h37;
    return v[3:0];
  endfunction

  // active-low, bit order {g,f,e,d,c,b,a}
  function automatic logic [SEG_W-1:0] seg_encode(input bcd_t d);
    logic [SEG_W-1:0] on;
    case (d)
      4'd0: on = 7'h3F;
      4'd1: on = 7'h06;
      4'd2: on = 7'h5B;
      4'd3: on = 7'h4F;
      4'd4: on = 7'h66;
      4'd5: on = 7'h6D;
      4'd6: on = 7'h7D;
      4'd7: on = 7'h07;
      4'd8: on = 7'h7F;
      4'd9: on = 7'h6F;
      default: on = 7'h00;
    endcase
    return ~on;
  endfunction

endpackage

// File: rtl/nmea_framer.sv
module nmea_framer
  import nmea_pkg::*;
#(
  parameter int MAX_LEN = 82,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output phase_t           phase_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             evt_start,
  output logic             evt_body,
  output logic             evt_star,
  output logic             evt_sum_ok,
  output logic             evt_drop
);

  phase_t           phase_d;
  logic [CNT_W-1:0] cnt_d;
  logic [7:0]       sum_q, sum_d;
  logic [3:0]       hi_q, hi_d;
  logic             at_limit;

  assign at_limit = (cnt_q == CNT_W'(MAX_LEN));

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    sum_d      = sum_q;
    hi_d       = hi_q;
    evt_start  = 1'b0;
    evt_body   = 1'b0;
    evt_star   = 1'b0;
    evt_sum_ok = 1'b0;
    evt_drop   = 1'b0;
    if (rx_valid) begin
      if (rx_byte == CH_DOLLAR) begin
        evt_start = 1'b1;
        phase_d   = PH_BODY;
        cnt_d     = CNT_W'(1);
        sum_d     = 8'h00;
      end else if ((phase_q != PH_IDLE) && at_limit) begin
        evt_drop = 1'b1;
        phase_d  = PH_IDLE;
      end else begin
        case (phase_q)
          PH_BODY: begin
            cnt_d = cnt_q + CNT_W'(1);
            if (rx_byte == CH_STAR) begin
              evt_star = 1'b1;
              phase_d  = PH_CK_HI;
            end else begin
              evt_body = 1'b1;
              sum_d    = sum_q ^ rx_byte;
            end
          end
          PH_CK_HI: begin
            cnt_d = cnt_q + CNT_W'(1);
            if (is_hex(rx_byte)) begin
              hi_d    = hex_val(rx_byte);
              phase_d = PH_CK_LO;
            end else begin
              evt_drop = 1'b1;
              phase_d  = PH_IDLE;
            end
          end
          PH_CK_LO: begin
            cnt_d   = cnt_q + CNT_W'(1);
            phase_d = PH_IDLE;
            evt_sum_ok = is_hex(rx_byte) && ({hi_q, hex_val(rx_byte)} == sum_q);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sum_q   <= 8'h00;
      hi_q    <= 4'h0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sum_q   <= sum_d;
      hi_q    <= hi_d;
    end
  end

endmodule

// File: rtl/nmea_fields.sv
module nmea_fields
  import nmea_pkg::*;
#(
  parameter int TIME_FIELD = 1,
  parameter int DATE_FIELD = 9,
  parameter int FLD_W      = 5,
  parameter int POS_W      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_start,
  input  logic       evt_body,
  input  logic       evt_star,
  input  logic [7:0] rx_byte,
  output digits_t    time_stage,
  output digits_t    date_stage,
  output logic       sentence_ok
);

  logic [FLD_W-1:0] fld_q;
  logic [POS_W-1:0] pos_q;
  logic [23:0]      id_q;
  logic             fbad_q, rmc_q, time_ok_q, date_ok_q;
  logic             is_close, is_data, in_time, in_date, in_slot;

  assign is_close = evt_star || (evt_body && (rx_byte == CH_COMMA));
  assign is_data  = evt_body && (rx_byte != CH_COMMA);
  assign in_time  = (fld_q == FLD_W'(TIME_FIELD));
  assign in_date  = (fld_q == FLD_W'(DATE_FIELD));
  assign in_slot  = (pos_q < POS_W'(NDIG));

  assign sentence_ok = rmc_q && time_ok_q && date_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_q      <= '0;
      pos_q      <= '0;
      id_q       <= '0;
      fbad_q     <= 1'b0;
      rmc_q      <= 1'b0;
      time_ok_q  <= 1'b0;
      date_ok_q  <= 1'b0;
      time_stage <= '0;
      date_stage <= '0;
    end else if (evt_start) begin
      fld_q     <= '0;
      pos_q     <= '0;
      id_q      <= '0;
      fbad_q    <= 1'b0;
      rmc_q     <= 1'b0;
      time_ok_q <= 1'b0;
      date_ok_q <= 1'b0;
    end else if (is_close) begin
      if (fld_q == '0) rmc_q <= (id_q == "RMC");
      if (in_time) time_ok_q <= !fbad_q && (pos_q >= POS_W'(NDIG));
      if (in_date) date_ok_q <= !fbad_q && (pos_q == POS_W'(NDIG));
      fbad_q <= 1'b0;
      pos_q  <= '0;
      if (fld_q != '1) fld_q <= fld_q + FLD_W'(1);
    end else if (is_data) begin
      if (pos_q != '1) pos_q <= pos_q + POS_W'(1);
      if (fld_q == '0) id_q <= {id_q[15:0], rx_byte};
      if ((in_time || in_date) && in_slot) begin
        if (!is_dec(rx_byte)) begin
          fbad_q <= 1'b1;
        end else begin
          for (int i = 0; i < NDIG; i++) begin
            if (pos_q == POS_W'(i)) begin
              if (in_time) time_stage[i] <= rx_byte[3:0];
              else         date_stage[i] <= rx_byte[3:0];
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/nmea_display.sv
module nmea_display
  import nmea_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  evt_commit,
  input  digits_t               time_stage,
  input  digits_t               date_stage,
  input  logic                  show_date,
  output digits_t               time_q,
  output digits_t               date_q,
  output logic                  disp_valid,
  output logic [NDIG*SEG_W-1:0] seg_n
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q     <= '0;
      date_q     <= '0;
      disp_valid <= 1'b0;
    end else if (evt_commit) begin
      time_q     <= time_stage;
      date_q     <= date_stage;
      disp_valid <= 1'b1;
    end
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    bcd_t pick;
    assign pick = show_date ? date_q[g] : time_q[g];
    assign seg_n[(NDIG-1-g)*SEG_W +: SEG_W] = disp_valid ? seg_encode(pick) : SEG_BLANK;
  end

endmodule

// File: rtl/nmea_clock_display.sv
module nmea_clock_display
  import nmea_pkg::*;
#(
  parameter int MAX_LEN    = 82,
  parameter int TIME_FIELD = 1,
  parameter int DATE_FIELD = 9,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_byte,
  input  logic                  show_date,
  output logic [NDIG*SEG_W-1:0] seg_n,
  output logic                  disp_valid
);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             evt_start, evt_body, evt_star, evt_sum_ok, evt_drop;
  logic             sentence_ok, evt_commit;
  digits_t          time_stage, date_stage, time_q, date_q;

  nmea_framer #(.MAX_LEN(MAX_LEN)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .phase_q    (phase_q),
    .cnt_q      (cnt_q),
    .evt_start  (evt_start),
    .evt_body   (evt_body),
    .evt_star   (evt_star),
    .evt_sum_ok (evt_sum_ok),
    .evt_drop   (evt_drop)
  );

  nmea_fields #(.TIME_FIELD(TIME_FIELD), .DATE_FIELD(DATE_FIELD)) u_fields (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_start   (evt_start),
    .evt_body    (evt_body),
    .evt_star    (evt_star),
    .rx_byte     (rx_byte),
    .time_stage  (time_stage),
    .date_stage  (date_stage),
    .sentence_ok (sentence_ok)
  );

  assign evt_commit = evt_sum_ok && sentence_ok;

  nmea_display u_display (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_commit (evt_commit),
    .time_stage (time_stage),
    .date_stage (date_stage),
    .show_date  (show_date),
    .time_q     (time_q),
    .date_q     (date_q),
    .disp_valid (disp_valid),
    .seg_n      (seg_n)
  );

endmodule

// File: rtl/nmea_display_checker.sv
module nmea_display_checker
  import nmea_pkg::*;
#(
  parameter int MAX_LEN = 82,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rx_valid,
  input logic [NDIG*SEG_W-1:0] seg_n,
  input logic                  disp_valid,
  input phase_t                phase_q,
  input logic [CNT_W-1:0]      cnt_q,
  input logic                  evt_commit,
  input logic                  evt_drop,
  input digits_t               time_q,
  input digits_t               date_q
);

  function automatic logic all_bcd(input digits_t d);
    logic ok = 1'b1;
    for (int i = 0; i < NDIG; i++) if (d[i] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  a_r1_dark_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid |-> (seg_n == {NDIG*SEG_W{1'b1}}));

  a_r2_valid_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> disp_valid);

  a_r2_commit_shows: assert property (@(posedge clk) disable iff (!rst_n)
    evt_commit |=> disp_valid);

  a_r5_commit_at_checksum: assert property (@(posedge clk) disable iff (!rst_n)
    evt_commit |-> (rx_valid && (phase_q == PH_CK_LO)));

  a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_commit |=> ($stable(time_q) && $stable(date_q)));

  a_r4_digits_decimal: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (all_bcd(time_q) && all_bcd(date_q)));

  a_r9_length_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_LEN));

  a_r9_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |=> (phase_q == PH_IDLE));

  a_r11_idle_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> ($stable(phase_q) && $stable(cnt_q)));

endmodule

bind nmea_clock_display nmea_display_checker #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .seg_n      (seg_n),
  .disp_valid (disp_valid),
  .phase_q    (phase_q),
  .cnt_q      (cnt_q),
  .evt_commit (evt_commit),
  .evt_drop   (evt_drop),
  .time_q     (time_q),
  .date_q     (date_q)
);

// File: tb/tb_nmea_clock_display.sv
`timescale 1ns/1ps
module tb_nmea_clock_display;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        show_date = 1'b0;
  logic [41:0] seg_n;
  logic        disp_valid;

  int n_cmp = 0;
  int n_bad = 0;
  string exp_t = "000000";
  string exp_d = "000000";
  bit    exp_v = 1'b0;

  always #2 clk = ~clk;

  nmea_clock_display dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .show_date(show_date), .seg_n(seg_n), .disp_valid(disp_valid)
  );

  function automatic logic [6:0] want_seg(input int d);
    string lit [10] = '{"abcdef", "bc", "abdeg", "abcdg", "bcfg",
                        "acdfg", "acdefg", "abc", "abcdefg", "abcdfg"};
    logic [6:0] m = 7'h00;
    for (int k = 0; k < lit[d].len(); k++) m[lit[d][k] - 8'h61] = 1'b1;
    return ~m;
  endfunction

  function automatic logic [41:0] want_word(input string digs, input bit v);
    logic [41:0] w;
    for (int i = 0; i < 6; i++)
      w[(5-i)*7 +: 7] = v ? want_seg(int'(digs[i]) - 48) : 7'h7F;
    return w;
  endfunction

  task automatic compare(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_disp(input string tag);
    @(negedge clk);
    show_date = 1'b0; #1;
    compare({tag, " valid"}, 64'(disp_valid), 64'(exp_v));
    compare({tag, " time"}, 64'(seg_n), 64'(want_word(exp_t, exp_v)));
    show_date = 1'b1; #1;
    compare({tag, " date"}, 64'(seg_n), 64'(want_word(exp_d, exp_v)));
    show_date = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input bit gap);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (gap) begin
      rx_byte = 8'h24;
      @(negedge clk);
      rx_byte = 8'h31;
    end
  endtask

  task automatic send_raw(input string s);
    for (int i = 0; i < s.len(); i++) put_byte(s[i], 1'b0);
  endtask

  function automatic string body_of(input string id, input string t, input string d);
    return {id, ",", t, ",A,4807.038,N,01131.000,E,022.4,084.4,", d, ",003.1,W"};
  endfunction

  function automatic string framed(input string body, input logic [7:0] flip, input bit lower);
    logic [7:0] x = 8'h00;
    for (int i = 0; i < body.len(); i++) x ^= body[i];
    x ^= flip;
    return {"$", body, "*", lower ? $sformatf("%02x", x) : $sformatf("%02X", x)};
  endfunction

  task automatic send_sentence(input string body, input logic [7:0] flip, input bit lower, input bit gap);
    string s = framed(body, flip, lower);
    for (int i = 0; i < s.len(); i++) put_byte(s[i], gap);
    put_byte(8'h0D, 1'b0);
    put_byte(8'h0A, 1'b0);
  endtask

  function automatic string padded(input string t, input string d, input int total);
    string b = {body_of("GPRMC", t, d), ","};
    while (b.len() < total - 4) b = {b, "Z"};
    return b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check_disp("R1 in reset");
    rst_n = 1'b1;
    check_disp("R1 after reset");

    // R6: correct checksum but not the RMC type, before anything was accepted
    send_sentence(body_of("GPGGA", "101010", "111111"), 8'h00, 1'b0, 1'b0);
    check_disp("R6 non-RMC before first");

    // R2 / R3: first accepted sentence
    send_sentence(body_of("GPRMC", "123519", "230394"), 8'h00, 1'b0, 1'b0);
    exp_v = 1'b1; exp_t = "123519"; exp_d = "230394";
    check_disp("R2 R3 first accept");

    // R4: every digit value at every position, both selects
    for (int k = 0; k < 10; k++) begin
      string t = "000000";
      string d = "000000";
      for (int i = 0; i < 6; i++) begin
        t[i] = 8'(48 + (k + i) % 10);
        d[i] = 8'(48 + (k + 9 - i) % 10);
      end
      send_sentence(body_of("GNRMC", t, d), 8'h00, 1'b0, 1'b0);
      exp_t = t; exp_d = d;
      check_disp($sformatf("R4 sweep %0d", k));
    end

    // R5: each checksum bit corrupted in turn leaves the display alone
    for (int b = 0; b < 8; b++) begin
      send_sentence(body_of("GPRMC", "010203", "040506"), 8'(1 << b), 1'b0, 1'b0);
      check_disp($sformatf("R5 flipped bit %0d", b));
    end
    send_sentence(body_of("GPRMC", "235959", "311299"), 8'h00, 1'b1, 1'b0);
    exp_t = "235959"; exp_d = "311299";
    check_disp("R5 lower-case hex accepted");

    // R7: malformed numeric fields
    send_sentence(body_of("GPRMC", "12a456", "010101"), 8'h00, 1'b0, 1'b0);
    check_disp("R7 letter in time");
    send_sentence(body_of("GPRMC", "12345", "010101"), 8'h00, 1'b0, 1'b0);
    check_disp("R7 short time");
    send_sentence(body_of("GPRMC", "111111", "0101"), 8'h00, 1'b0, 1'b0);
    check_disp("R7 short date");
    send_sentence(body_of("GPRMC", "111111", "0101017"), 8'h00, 1'b0, 1'b0);
    check_disp("R7 long date");
    send_sentence(body_of("GPRMC", "111111", "01x101"), 8'h00, 1'b0, 1'b0);
    check_disp("R7 letter in date");

    // R10: fractional seconds ignored
    send_sentence(body_of("GPRMC", "084512.75", "150822"), 8'h00, 1'b0, 1'b0);
    exp_t = "084512"; exp_d = "150822";
    check_disp("R10 time suffix");

    // R8: restart in the middle of a sentence
    send_raw("$GPRMC,99");
    send_sentence(body_of("GPRMC", "070809", "101112"), 8'h00, 1'b0, 1'b0);
    exp_t = "070809"; exp_d = "101112";
    check_disp("R8 restart on dollar");
    send_raw("$GPRMC,121212,A,1,N,2,E,3,4,121212,5,W*");
    send_sentence(body_of("GPGSV", "333333", "333333"), 8'h00, 1'b0, 1'b0);
    check_disp("R8 R6 restart after star into other type");

    // R9: length limit
    send_sentence(padded("222222", "333333", 82), 8'h00, 1'b0, 1'b0);
    exp_t = "222222"; exp_d = "333333";
    check_disp("R9 exactly 82 accepted");
    send_sentence(padded("444444", "555555", 83), 8'h00, 1'b0, 1'b0);
    check_disp("R9 83 dropped");

    // R11: bytes without the strobe, including dollar signs, are ignored
    send_sentence(body_of("GPRMC", "161718", "192021"), 8'h00, 1'b0, 1'b1);
    exp_t = "161718"; exp_d = "192021";
    check_disp("R11 gaps ignored");

    // R6: other sentence type after a good one
    send_sentence(body_of("GPGGA", "000000", "000000"), 8'h00, 1'b0, 1'b0);
    check_disp("R6 non-RMC kept");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule